// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This block joins two eight-line interrupt controllers, a primary and a secondary, into one sixteen-line interrupt system. It sends each of the sixteen global request lines to the controller that owns that line. While the secondary controller has a deliverable interrupt, the block pulses primary line 2 so that the primary sees an edge on its cascade input.

The controllers themselves sit outside this block. Each controller reports its resolved winner to the block as a valid flag and a 3-bit line number. The block drives back the acknowledge strobes and the clear strobes. A CPU interrupt acknowledge takes one request cycle, and the block returns an 8-bit vector on the next cycle. The acknowledge walks the primary controller first and then the secondary. When no winner is found at a level, line 7 stands in as the spurious line.

The block also serves polled reads. A poll of one controller returns that controller's winning line, or 7 when nothing is pending, and retires the winning line in the same step. A combined acknowledge read polls the primary and then the secondary, returns a number in the range 0 to 15, and asks the primary controller to switch its status read to the in-service register.

Top module: `cascade_ack_unit`

## Requirements
- R1: Global line k drives primary line k[2:0] when bit 3 of k is 0, and it drives secondary line k[2:0] when bit 3 is 1. Primary line 2 is global line 2 ORed with the cascade pulse.
- R2: While `slv_valid_i` is held high, the cascade pulse is high on the first cycle after it rises and then alternates low and high on every following cycle. While `slv_valid_i` is low, the pulse stays low.
- R3: A cycle with `ack_req_i` high is followed by exactly one cycle of `ack_valid_o` high. In that cycle `vector_o` = {base[4:0], line[2:0]}.
- R4: If the primary has a winner that is not line 2, the block raises `mst_ack_o` in the request cycle with that line. The vector is then the primary base with that line.
- R5: If the primary winner is line 2 and the secondary has a winner, the block acknowledges both controllers. The vector is the secondary base with the secondary line.
- R6: If the primary winner is line 2 and the secondary has no winner, the vector is the secondary base with line 7, and `slv_ack_o` stays low.
- R7: If the primary has no winner, the vector is the primary base with line 7, and neither acknowledge strobe rises.
- R8: `reeval_o` is high in every cycle in which `ack_valid_o` or `rd_valid_o` is high.
- R9: A poll of the primary (`poll_slv_i`=0) gives `rd_data_o` = winning line, or 7, on the next cycle. In the request cycle it raises `mst_clr_o` with that line, but only when a winner exists.
- R10: A poll of the secondary (`poll_slv_i`=1) with a winner raises `slv_clr_o` with that line and `mst_clr_o` with line 2, and returns the line. Without a winner it returns 7 and raises no clear strobe.
- R11: A combined acknowledge read returns 8 + secondary line when the primary winner is 2, or 15 when the primary winner is 2 but the secondary has none. It returns the primary line when the primary winner is not 2, and 7 when the primary has no winner. `rsel_isr_o` pulses together with its `rd_valid_o`.
- R12: When requests arrive in the same cycle, acknowledge beats the combined read, and the combined read beats a poll. A losing request raises no strobe and no `rd_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Global request lines |
| mst_irq_o | output | 8 | Request lines to the primary controller |
| slv_irq_o | output | 8 | Request lines to the secondary controller |
| mst_valid_i | input | 1 | Primary has a deliverable winner |
| mst_line_i | input | 3 | Primary winning line |
| slv_valid_i | input | 1 | Secondary has a deliverable winner |
| slv_line_i | input | 3 | Secondary winning line |
| mst_base_i | input | 5 | Primary vector base, upper five bits |
| slv_base_i | input | 5 | Secondary vector base, upper five bits |
| ack_req_i | input | 1 | CPU interrupt acknowledge request |
| mmack_req_i | input | 1 | Combined acknowledge read request |
| poll_req_i | input | 1 | Poll read request |
| poll_slv_i | input | 1 | Poll target: 0 primary, 1 secondary |
| mst_ack_o | output | 1 | Acknowledge strobe to the primary |
| mst_ack_line_o | output | 3 | Line acknowledged on the primary |
| slv_ack_o | output | 1 | Acknowledge strobe to the secondary |
| slv_ack_line_o | output | 3 | Line acknowledged on the secondary |
| mst_clr_o | output | 1 | Clear request and in-service bits on the primary |
| mst_clr_line_o | output | 3 | Line cleared on the primary |
| slv_clr_o | output | 1 | Clear request and in-service bits on the secondary |
| slv_clr_line_o | output | 3 | Line cleared on the secondary |
| ack_valid_o | output | 1 | Vector valid |
| vector_o | output | 8 | Interrupt vector |
| rd_valid_o | output | 1 | Poll read data valid |
| rd_data_o | output | 8 | Poll read data |
| rsel_isr_o | output | 1 | Tells the primary to select its in-service register for status reads |
| reeval_o | output | 1 | Re-evaluate the interrupt output |

## Verification
The acknowledge path is driven from a table of controller states. The table covers a plain primary winner at low and high line numbers, a cascade winner with a secondary winner, a cascade winner with an empty secondary, and an empty primary. Each row separates one vector base and line choice, and one pattern of acknowledge strobes, from the others. Directed tests check the routing with a pattern split across the two halves and the cascade pulse with line 2 held low. They also check each poll form with a winner and without one, and simultaneous requests, which show whether the priority order suppresses the losing request's strobes and data.

// File: rtl/cv_pkg.sv
package cv_pkg;
  localparam int LINE_W    = 3;
  localparam int N_LINES   = 1 << LINE_W;
  localparam int VEC_W     = 8;
  localparam int BASE_W    = VEC_W - LINE_W;
  localparam int GLOBAL_N  = 2 * N_LINES;
  localparam logic [LINE_W-1:0] CASC_LINE = 3'd2;
  localparam logic [LINE_W-1:0] SPUR_LINE = 3'd7;

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [BASE_W-1:0] base_t;
  typedef logic [VEC_W-1:0]  vec_t;

  function automatic vec_t form_vec(base_t b, line_t l);
    return {b, l};
  endfunction
endpackage

// File: rtl/cv_route.sv
module cv_route
  import cv_pkg::*;
(
  input  logic [GLOBAL_N-1:0] irq_i,
  input  logic                casc_i,
  output logic [N_LINES-1:0]  mst_irq_o,
  output logic [N_LINES-1:0]  slv_irq_o
);
  for (genvar g = 0; g < GLOBAL_N; g++) begin : g_line
    if (g < N_LINES) begin : g_mst
      if (g == int'(CASC_LINE)) begin : g_casc
        assign mst_irq_o[g] = irq_i[g] | casc_i;
      end else begin : g_plain
        assign mst_irq_o[g] = irq_i[g];
      end
    end else begin : g_slv
      assign slv_irq_o[g-N_LINES] = irq_i[g];
    end
  end
endmodule

// File: rtl/cv_cascade.sv
module cv_cascade (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slv_valid_i,
  output logic casc_o
);
  logic casc_q;
  // high-then-low so the primary sees a fresh edge each time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) casc_q <= 1'b0;
    else         casc_q <= slv_valid_i & ~casc_q;
  end
  assign casc_o = casc_q;
endmodule

// File: rtl/cv_ack.sv
module cv_ack
  import cv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  req_i,
  input  logic  mst_valid_i,
  input  line_t mst_line_i,
  input  logic  slv_valid_i,
  input  line_t slv_line_i,
  input  base_t mst_base_i,
  input  base_t slv_base_i,
  output logic  mst_ack_o,
  output line_t mst_ack_line_o,
  output logic  slv_ack_o,
  output line_t slv_ack_line_o,
  output logic  valid_o,
  output vec_t  vec_o
);
  logic casc;
  vec_t vec_d, vec_q;
  logic valid_q;

  assign casc           = mst_valid_i && (mst_line_i == CASC_LINE);
  assign mst_ack_o      = req_i && mst_valid_i;
  assign mst_ack_line_o = mst_line_i;
  assign slv_ack_o      = req_i && casc && slv_valid_i;
  assign slv_ack_line_o = slv_line_i;

  always_comb begin
    if (!mst_valid_i)      vec_d = form_vec(mst_base_i, SPUR_LINE);
    else if (!casc)        vec_d = form_vec(mst_base_i, mst_line_i);
    else if (slv_valid_i)  vec_d = form_vec(slv_base_i, slv_line_i);
    else                   vec_d = form_vec(slv_base_i, SPUR_LINE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= req_i;
      if (req_i) vec_q <= vec_d;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = vec_q;
endmodule

// File: rtl/cv_poll.sv
module cv_poll
  import cv_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  poll_i,
  input  logic  poll_slv_i,
  input  logic  mm_i,
  input  logic  mst_valid_i,
  input  line_t mst_line_i,
  input  logic  slv_valid_i,
  input  line_t slv_line_i,
  output logic  mst_clr_o,
  output line_t mst_clr_line_o,
  output logic  slv_clr_o,
  output line_t slv_clr_line_o,
  output logic  valid_o,
  output vec_t  data_o,
  output logic  rsel_o
);
  vec_t data_d, data_q;
  logic valid_q, rsel_q;

  always_comb begin
    mst_clr_o      = 1'b0;
    mst_clr_line_o = mst_line_i;
    slv_clr_o      = 1'b0;
    slv_clr_line_o = slv_line_i;
    data_d         = {{(VEC_W-LINE_W){1'b0}}, SPUR_LINE};
    if (mm_i) begin
      if (mst_valid_i) begin
        mst_clr_o = 1'b1;
        if (mst_line_i == CASC_LINE) begin
          slv_clr_o = slv_valid_i;
          data_d    = {{(VEC_W-LINE_W-1){1'b0}}, 1'b1,
                       slv_valid_i ? slv_line_i : SPUR_LINE};
        end else begin
          data_d = {{(VEC_W-LINE_W){1'b0}}, mst_line_i};
        end
      end
    end else if (poll_i) begin
      if (poll_slv_i) begin
        if (slv_valid_i) begin
          slv_clr_o      = 1'b1;
          mst_clr_o      = 1'b1;
          mst_clr_line_o = CASC_LINE;
          data_d         = {{(VEC_W-LINE_W){1'b0}}, slv_line_i};
        end
      end else if (mst_valid_i) begin
        mst_clr_o = 1'b1;
        data_d    = {{(VEC_W-LINE_W){1'b0}}, mst_line_i};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      rsel_q  <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= mm_i | poll_i;
      rsel_q  <= mm_i;
      if (mm_i | poll_i) data_q <= data_d;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign rsel_o  = rsel_q;
endmodule

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit
  import cv_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] irq_i,
  output logic [7:0]  mst_irq_o,
  output logic [7:0]  slv_irq_o,
  input  logic        mst_valid_i,
  input  logic [2:0]  mst_line_i,
  input  logic        slv_valid_i,
  input  logic [2:0]  slv_line_i,
  input  logic [4:0]  mst_base_i,
  input  logic [4:0]  slv_base_i,
  input  logic        ack_req_i,
  input  logic        mmack_req_i,
  input  logic        poll_req_i,
  input  logic        poll_slv_i,
  output logic        mst_ack_o,
  output logic [2:0]  mst_ack_line_o,
  output logic        slv_ack_o,
  output logic [2:0]  slv_ack_line_o,
  output logic        mst_clr_o,
  output logic [2:0]  mst_clr_line_o,
  output logic        slv_clr_o,
  output logic [2:0]  slv_clr_line_o,
  output logic        ack_valid_o,
  output logic [7:0]  vector_o,
  output logic        rd_valid_o,
  output logic [7:0]  rd_data_o,
  output logic        rsel_isr_o,
  output logic        reeval_o
);
  logic casc;
  logic mm_win, poll_win;

  // fixed order: acknowledge, combined read, poll
  assign mm_win   = mmack_req_i & ~ack_req_i;
  assign poll_win = poll_req_i & ~ack_req_i & ~mmack_req_i;

  cv_cascade u_casc (
    .clk_i(clk_i), .rst_ni(rst_ni), .slv_valid_i(slv_valid_i), .casc_o(casc)
  );

  cv_route u_route (
    .irq_i(irq_i), .casc_i(casc), .mst_irq_o(mst_irq_o), .slv_irq_o(slv_irq_o)
  );

  cv_ack u_ack (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(ack_req_i),
    .mst_valid_i(mst_valid_i), .mst_line_i(mst_line_i),
    .slv_valid_i(slv_valid_i), .slv_line_i(slv_line_i),
    .mst_base_i(mst_base_i), .slv_base_i(slv_base_i),
    .mst_ack_o(mst_ack_o), .mst_ack_line_o(mst_ack_line_o),
    .slv_ack_o(slv_ack_o), .slv_ack_line_o(slv_ack_line_o),
    .valid_o(ack_valid_o), .vec_o(vector_o)
  );

  cv_poll u_poll (
    .clk_i(clk_i), .rst_ni(rst_ni), .poll_i(poll_win), .poll_slv_i(poll_slv_i),
    .mm_i(mm_win),
    .mst_valid_i(mst_valid_i), .mst_line_i(mst_line_i),
    .slv_valid_i(slv_valid_i), .slv_line_i(slv_line_i),
    .mst_clr_o(mst_clr_o), .mst_clr_line_o(mst_clr_line_o),
    .slv_clr_o(slv_clr_o), .slv_clr_line_o(slv_clr_line_o),
    .valid_o(rd_valid_o), .data_o(rd_data_o), .rsel_o(rsel_isr_o)
  );

  assign reeval_o = ack_valid_o | rd_valid_o;
endmodule

// File: rtl/cascade_ack_chk.sv
module cascade_ack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [15:0] irq_i,
  input logic [7:0] mst_irq_o,
  input logic       mst_valid_i,
  input logic       slv_valid_i,
  input logic       ack_req_i,
  input logic       mmack_req_i,
  input logic       poll_req_i,
  input logic       mst_ack_o,
  input logic [2:0] mst_ack_line_o,
  input logic       slv_ack_o,
  input logic       mst_clr_o,
  input logic       slv_clr_o,
  input logic [2:0] mst_clr_line_o,
  input logic       ack_valid_o,
  input logic       rd_valid_o,
  input logic       rsel_isr_o,
  input logic       reeval_o
);
  p_casc_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_irq_o[2] && !irq_i[2]) |=> (!mst_irq_o[2] || irq_i[2]));

  p_ack_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_i |=> ack_valid_o);

  p_ack_once_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_req_i |=> !ack_valid_o);

  p_slv_ack_casc_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slv_ack_o |-> (mst_ack_o && mst_ack_line_o == 3'd2));

  p_no_ack_empty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_ack_o |-> mst_valid_i);

  p_reeval_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_o || rd_valid_o) |-> reeval_o);

  p_slv_poll_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_clr_o && poll_req_i && !mmack_req_i) |-> (mst_clr_o && mst_clr_line_o == 3'd2));

  p_rsel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsel_isr_o |-> rd_valid_o);

  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mst_ack_o && mst_clr_o));

  p_ack_blocks_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_i |=> !rd_valid_o);

  p_slv_needs_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_clr_o || slv_ack_o) |-> slv_valid_i);
endmodule

bind cascade_ack_unit cascade_ack_chk u_chk (.*);

// File: tb/tb_cascade_ack_unit.sv
module tb_cascade_ack_unit;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [15:0] irq;
  logic [7:0]  mst_irq, slv_irq;
  logic        mv, sv, ack, mm, poll, pslv;
  logic [2:0]  ml, sl;
  logic [4:0]  mb, sb;
  logic        mack, sack, mclr, sclr, avld, rvld, rsel, reev;
  logic [2:0]  mackl, sackl, mclrl, sclrl;
  logic [7:0]  vec, rdat;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  cascade_ack_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .mst_irq_o(mst_irq), .slv_irq_o(slv_irq),
    .mst_valid_i(mv), .mst_line_i(ml), .slv_valid_i(sv), .slv_line_i(sl),
    .mst_base_i(mb), .slv_base_i(sb), .ack_req_i(ack), .mmack_req_i(mm),
    .poll_req_i(poll), .poll_slv_i(pslv), .mst_ack_o(mack), .mst_ack_line_o(mackl),
    .slv_ack_o(sack), .slv_ack_line_o(sackl), .mst_clr_o(mclr), .mst_clr_line_o(mclrl),
    .slv_clr_o(sclr), .slv_clr_line_o(sclrl), .ack_valid_o(avld), .vector_o(vec),
    .rd_valid_o(rvld), .rd_data_o(rdat), .rsel_isr_o(rsel), .reeval_o(reev)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {mv, ml, sv, sl, vector, mst_ack, slv_ack}; bases 5'h04 -> 0x20, 5'h0E -> 0x70
  localparam logic [17:0] ACK_TBL [6] = '{
    {1'b1, 3'd0, 1'b0, 3'd0, 8'h20, 1'b1, 1'b0},   // R4
    {1'b1, 3'd5, 1'b1, 3'd4, 8'h25, 1'b1, 1'b0},   // R4
    {1'b1, 3'd2, 1'b1, 3'd3, 8'h73, 1'b1, 1'b1},   // R5
    {1'b1, 3'd2, 1'b0, 3'd6, 8'h77, 1'b1, 1'b0},   // R6
    {1'b0, 3'd1, 1'b1, 3'd1, 8'h27, 1'b0, 1'b0},   // R7
    {1'b1, 3'd7, 1'b0, 3'd0, 8'h27, 1'b1, 1'b0}    // R4
  };

  task automatic do_poll(input bit is_mm, input bit to_slv, input bit m_v, input logic [2:0] m_l,
                         input bit s_v, input logic [2:0] s_l, input bit e_mclr,
                         input logic [2:0] e_mclrl, input bit e_sclr, input logic [7:0] e_dat,
                         input string tag);
    @(negedge clk);
    mv = m_v; ml = m_l; sv = s_v; sl = s_l; mm = is_mm; poll = !is_mm; pslv = to_slv;
    #1;
    chk(mclr == e_mclr, {tag, " mst_clr"}, mclr, e_mclr);
    if (e_mclr) chk(mclrl == e_mclrl, {tag, " mst_clr_line"}, mclrl, e_mclrl);
    chk(sclr == e_sclr, {tag, " slv_clr"}, sclr, e_sclr);
    if (e_sclr) chk(sclrl == s_l, {tag, " slv_clr_line"}, sclrl, s_l);
    @(negedge clk);
    mm = 0; poll = 0; #1;
    chk(rvld && rdat == e_dat, {tag, " rd_data"}, rdat, e_dat);
    chk(rsel == is_mm, {tag, " rsel"}, rsel, is_mm);
    chk(reev == 1'b1, "R8 reeval on read", reev, 1);
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    irq = '0; mv = 0; sv = 0; ml = 0; sl = 0; mb = 5'h04; sb = 5'h0E;
    ack = 0; mm = 0; poll = 0; pslv = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!avld && !rvld && !reev && !rsel && mst_irq == 8'h00, "reset state", {avld, rvld, reev}, 0);
    rst_n = 1;

    // R1 routing
    @(negedge clk); irq = 16'h3C_A1; #1;
    chk(mst_irq == 8'hA1, "R1 primary lines", mst_irq, 8'hA1);
    chk(slv_irq == 8'h3C, "R1 secondary lines", slv_irq, 8'h3C);
    irq = 16'h0004; #1;
    chk(mst_irq == 8'h04, "R1 global line 2", mst_irq, 8'h04);
    irq = '0;

    // R2 cascade pulse
    @(negedge clk); sv = 1; #1;
    chk(mst_irq[2] == 1'b0, "R2 before edge", mst_irq[2], 0);
    @(negedge clk); #1; chk(mst_irq[2] == 1'b1, "R2 pulse high", mst_irq[2], 1);
    @(negedge clk); #1; chk(mst_irq[2] == 1'b0, "R2 pulse low", mst_irq[2], 0);
    @(negedge clk); #1; chk(mst_irq[2] == 1'b1, "R2 pulse high again", mst_irq[2], 1);
    sv = 0;
    @(negedge clk); @(negedge clk); #1;
    chk(mst_irq[2] == 1'b0, "R2 idle low", mst_irq[2], 0);

    // R3-R7 acknowledge table
    for (int i = 0; i < 6; i++) begin
      logic [17:0] e;
      e = ACK_TBL[i];
      @(negedge clk);
      mv = e[17]; ml = e[16:14]; sv = e[13]; sl = e[12:10]; ack = 1; #1;
      chk(mack == e[1], "R4 R7 mst_ack", mack, e[1]);
      if (e[1]) chk(mackl == e[16:14], "R4 mst_ack_line", mackl, e[16:14]);
      chk(sack == e[0], "R5 R6 slv_ack", sack, e[0]);
      if (e[0]) chk(sackl == e[12:10], "R5 slv_ack_line", sackl, e[12:10]);
      @(negedge clk); ack = 0; #1;
      chk(avld == 1'b1, "R3 ack_valid", avld, 1);
      chk(vec == e[9:2], "R3 vector", vec, e[9:2]);
      chk(reev == 1'b1, "R8 reeval on ack", reev, 1);
      @(negedge clk); #1;
      chk(avld == 1'b0, "R3 single valid", avld, 0);
    end
    sv = 0;

    // R9 primary poll
    do_poll(0, 0, 1, 3'd4, 0, 3'd0, 1, 3'd4, 0, 8'd4, "R9 winner");
    do_poll(0, 0, 0, 3'd4, 1, 3'd2, 0, 3'd0, 0, 8'd7, "R9 empty");
    // R10 secondary poll
    do_poll(0, 1, 1, 3'd1, 1, 3'd6, 1, 3'd2, 1, 8'd6, "R10 winner");
    do_poll(0, 1, 1, 3'd1, 0, 3'd6, 0, 3'd0, 0, 8'd7, "R10 empty");
    // R11 combined read
    do_poll(1, 0, 1, 3'd2, 1, 3'd1, 1, 3'd2, 1, 8'd9,  "R11 cascade");
    do_poll(1, 0, 1, 3'd2, 0, 3'd1, 1, 3'd2, 0, 8'd15, "R11 cascade empty");
    do_poll(1, 0, 1, 3'd5, 1, 3'd1, 1, 3'd5, 0, 8'd5,  "R11 primary");
    do_poll(1, 0, 0, 3'd5, 1, 3'd1, 0, 3'd0, 0, 8'd7,  "R11 empty");

    // R12 priority: ack with poll and combined read
    @(negedge clk);
    mv = 1; ml = 3'd3; sv = 1; sl = 3'd0; ack = 1; poll = 1; mm = 1; pslv = 1; #1;
    chk(!mclr && !sclr, "R12 no clear under ack", {mclr, sclr}, 0);
    @(negedge clk); ack = 0; poll = 0; mm = 0; #1;
    chk(!rvld, "R12 no read data under ack", rvld, 0);
    chk(avld && vec == 8'h23, "R12 ack served", vec, 8'h23);
    // combined read beats poll
    @(negedge clk);
    mv = 1; ml = 3'd6; sv = 1; sl = 3'd5; mm = 1; poll = 1; pslv = 1; #1;
    chk(mclr && mclrl == 3'd6 && !sclr, "R12 combined read wins", mclrl, 6);
    @(negedge clk); mm = 0; poll = 0; #1;
    chk(rvld && rdat == 8'd6 && rsel, "R12 combined read data", rdat, 6);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule